// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Generation

This block is the purely combinational arithmetic and logic unit of a small accumulator CPU. The CPU presents an operation code, the accumulator value, a second operand and the current flag byte. In the same cycle the block returns an 8-bit result, a write enable for the accumulator and the next flag byte.

Each operation sets the zero, subtract, half-carry and carry flags by its own rules. Binary add and subtract share a single adder that reports the carry out of the low nibble and the carry out of the whole byte. The compare operation updates the flags and leaves the accumulator alone. Increment and decrement keep the incoming carry. A decimal-adjust operation reads the stored subtract, half-carry and carry flags and corrects the accumulator to packed BCD. Operand fetch, decode, the register file and memory are handled outside this block.

Top module: `acc_alu`

## Requirements
- R1: `op_sel` encodings: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 or, 6 xor, 7 compare, 8 increment, 9 decrement, 10 complement, 11 carry-complement, 12 carry-set, 13 decimal-adjust. The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4.
- R2: Add and add-with-carry give `acc + opnd (+ C)` mod 256, with N=0, H=carry out of bit 3, C=carry out of bit 7, and Z=result is zero.
- R3: Subtract and subtract-with-borrow give `acc - opnd (- C)` mod 256, with N=1, H=borrow into bit 3 from bit 4, C=borrow out of bit 7, and Z=result is zero.
- R4: Compare sets the flags exactly as a subtract does, drives `res_we` low, and outputs the unchanged accumulator on `res_out`.
- R5: And, or and xor give Z from the result and N=0, C=0. H is 1 for and and 0 for or and xor.
- R6: Increment and decrement change the accumulator by one. Both set Z from the result and pass C through. Increment sets N=0 and H on a low-nibble carry. Decrement sets N=1 and H on a low-nibble borrow.
- R7: Complement writes `~acc` and sets N=1 and H=1. Z and C pass through.
- R8: Carry-complement inverts C and carry-set forces C=1. Both clear N and H, keep Z, drive `res_we` low and output the unchanged accumulator.
- R9: Decimal-adjust with N=0 adds 0x06 when H=1 or the low nibble is above 9. It adds 0x60 and sets C when C=1 or acc is above 0x99, and otherwise keeps C.
- R10: Decimal-adjust with N=1 subtracts 0x06 when H=1 and 0x60 when C=1, and keeps C. In both directions of decimal-adjust, H=0, N passes through and Z comes from the result.
- R11: Op codes 14 and 15 drive `res_we` low, output the unchanged accumulator, and pass Z, N, H and C through.
- R12: Bits 3..0 of `flags_out` are always zero, whatever value `flags_in[3:0]` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte (Z,N,H,C in bits 7..4) |
| res_out | output | 8 | Operation result |
| res_we | output | 1 | Accumulator write enable |
| flags_out | output | 8 | Next flag byte |

## Verification
Directed vectors target the nibble and byte boundaries: 0x0F+1, 0xFF+1, 0x10-1, 0-1, decrement of 0x00 and increment of 0xFF with C set. These separate a half-carry taken from the wrong bit, and a carry that is wrongly updated, from correct behaviour. Decimal-adjust is tried after both adds and subtracts, including 0x9A, which must wrap to zero and set C. A long run of random operation codes, operands and flag bytes also covers the two undefined codes and nonzero low flag bits. Against every one of these vectors, the reference model checks the result, the write enable and all flags.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths, operation codes and flag bit positions for the ALU.
package acc_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMP = 4'd7,
        OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_CPL = 4'd10, OP_CCF = 4'd11,
        OP_SCF = 4'd12, OP_DAA = 4'd13
    } alu_op_e;

    // Flag bit positions inside the flag byte
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;
endpackage

// File: rtl/acc_alu_addsub.sv
// Module: shared add/subtract datapath.
// Computes a +/- b +/- cin and reports the low-nibble carry (or borrow)
// and the full-width carry (or borrow). Assumes W is even.
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         carry
);
    localparam int NW = W / 2;

    logic [NW:0] lo;
    logic [W:0]  full;

    // Low nibble arithmetic, only used for the half flag
    always_comb begin
        if (sub)
            lo = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        else
            lo = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    end

    // Full-width arithmetic with an extra bit for carry/borrow
    always_comb begin
        if (sub)
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        else
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign sum   = full[W-1:0];
    assign half  = lo[NW];
    assign carry = full[W];
endmodule

// File: rtl/acc_alu_logic.sv
// Module: bitwise and/or/xor/complement unit.
// mode: 0 and, 1 or, 2 xor, 3 invert a. Pure combinational.
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   mode,
    output logic [W-1:0] y
);
    // Per-bit function selected by mode
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (mode)
                2'd0:    y[i] = a[i] & b[i];
                2'd1:    y[i] = a[i] | b[i];
                2'd2:    y[i] = a[i] ^ b[i];
                default: y[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_daa.sv
// Module: decimal-adjust unit.
// Corrects a binary value to packed BCD using the stored subtract, half and
// carry flags. Assumes an 8-bit accumulator holding two BCD digits.
module acc_alu_daa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         n_in,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] y,
    output logic         c_out
);
    logic [W-1:0] corr;

    // Choose the correction constant and the outgoing carry
    always_comb begin
        corr  = '0;
        c_out = c_in;
        if (!n_in) begin
            if (h_in || (a[3:0] > 4'd9)) corr[3:0] = 4'h6;
            if (c_in || (a > 8'h99)) begin
                corr[7:4] = 4'h6;
                c_out     = 1'b1;
            end
        end else begin
            if (h_in) corr[3:0] = 4'h6;
            if (c_in) corr[7:4] = 4'h6;
        end
    end

    // Apply the correction in the direction of the previous operation
    assign y = n_in ? (a - corr) : (a + corr);
endmodule

// File: rtl/acc_alu.sv
// Module: 8-bit accumulator ALU, top level.
// Decodes the operation code, steers operands into the shared adder, the
// logic unit and the decimal-adjust unit, and builds the next flag byte.
// Fully combinational; assumes flags_in is the byte produced earlier.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic [7:0]        flags_out
);
    alu_op_e op;
    logic z_i, n_i, h_i, c_i;
    logic z_o, n_o, h_o, c_o;

    logic [DATA_W-1:0] as_b, as_sum;
    logic              as_cin, as_sub, as_half, as_carry;
    logic [1:0]        lg_mode;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] da_y;
    logic              da_c;

    assign op  = alu_op_e'(op_sel);
    assign z_i = flags_in[FZ];
    assign n_i = flags_in[FN];
    assign h_i = flags_in[FH];
    assign c_i = flags_in[FC];

    // Steer operands into the shared adder
    always_comb begin
        as_b   = opnd_in;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:         as_cin = c_i;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = c_i; end
            OP_INC: begin as_b = '0; as_cin = 1'b1; end
            OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            default: ;
        endcase
    end

    // Select the logic unit function
    always_comb begin
        case (op)
            OP_AND:  lg_mode = 2'd0;
            OP_OR:   lg_mode = 2'd1;
            OP_XOR:  lg_mode = 2'd2;
            default: lg_mode = 2'd3;
        endcase
    end

    acc_alu_addsub #(.W(DATA_W)) u_addsub (
        .a(acc_in), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .half(as_half), .carry(as_carry)
    );

    acc_alu_logic #(.W(DATA_W)) u_logic (
        .a(acc_in), .b(opnd_in), .mode(lg_mode), .y(lg_y)
    );

    acc_alu_daa #(.W(DATA_W)) u_daa (
        .a(acc_in), .n_in(n_i), .h_in(h_i), .c_in(c_i),
        .y(da_y), .c_out(da_c)
    );

    // Result, write enable and next flags per operation
    always_comb begin
        res_out = acc_in;
        res_we  = 1'b0;
        z_o = z_i; n_o = n_i; h_o = h_i; c_o = c_i;
        case (op)
            OP_ADD, OP_ADC: begin
                res_out = as_sum; res_we = 1'b1;
                z_o = (as_sum == '0); n_o = 1'b0; h_o = as_half; c_o = as_carry;
            end
            OP_SUB, OP_SBC: begin
                res_out = as_sum; res_we = 1'b1;
                z_o = (as_sum == '0); n_o = 1'b1; h_o = as_half; c_o = as_carry;
            end
            OP_CMP: begin
                z_o = (as_sum == '0); n_o = 1'b1; h_o = as_half; c_o = as_carry;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_out = lg_y; res_we = 1'b1;
                z_o = (lg_y == '0); n_o = 1'b0; h_o = (op == OP_AND); c_o = 1'b0;
            end
            OP_INC, OP_DEC: begin
                res_out = as_sum; res_we = 1'b1;
                z_o = (as_sum == '0); n_o = (op == OP_DEC); h_o = as_half;
            end
            OP_CPL: begin
                res_out = lg_y; res_we = 1'b1;
                n_o = 1'b1; h_o = 1'b1;
            end
            OP_CCF: begin n_o = 1'b0; h_o = 1'b0; c_o = ~c_i; end
            OP_SCF: begin n_o = 1'b0; h_o = 1'b0; c_o = 1'b1; end
            OP_DAA: begin
                res_out = da_y; res_we = 1'b1;
                z_o = (da_y == '0); h_o = 1'b0; c_o = da_c;
            end
            default: ;
        endcase
    end

    assign flags_out = {z_o, n_o, h_o, c_o, 4'b0000};

    // Guards on the outputs relative to the inputs
    always_comb begin
        if (op == OP_INC || op == OP_DEC) begin
            // R6
            incdec_keeps_carry_chk: assert (flags_out[FC] == flags_in[FC]);
        end
        if (op == OP_CMP) begin
            // R4
            cmp_acc_kept_chk: assert (!res_we && res_out == acc_in);
        end
        if (op == OP_DAA && n_i) begin
            // R10
            daa_sub_keeps_carry_chk: assert (flags_out[FC] == flags_in[FC]);
        end
        if (op == OP_AND) begin
            // R5
            and_flags_chk: assert (flags_out[FH] && !flags_out[FC] && !flags_out[FN]);
        end
        if (op == OP_SUB || op == OP_SBC) begin
            // R3
            sub_zero_chk: assert (flags_out[FN] && (flags_out[FZ] == (res_out == '0)));
        end
        if (op_sel > 4'd13) begin
            // R11
            undef_passthru_chk: assert (!res_we && flags_out[7:4] == flags_in[7:4]);
        end
    end
endmodule

// File: tb/acc_alu_bench.sv
// Bench: drives directed and random vectors and compares each one against
// a behavioural reference model.
module acc_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] op_sel;
    logic [7:0] acc_in, opnd_in, flags_in;
    logic [7:0] res_out, flags_out;
    logic       res_we;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_acc_alu (
        .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
        .flags_in(flags_in), .res_out(res_out), .res_we(res_we),
        .flags_out(flags_out)
    );

    function automatic string req_tag(int op);
        case (op)
            0, 1:    return "R2";
            2, 3:    return "R3";
            7:       return "R4";
            4, 5, 6: return "R5";
            8, 9:    return "R6";
            10:      return "R7";
            11, 12:  return "R8";
            default: return "R11";
        endcase
    endfunction

    // Reference model from the requirements
    task automatic model(input int op, input int a, input int b, input int f,
                         output int r, output int we, output int fo);
        int z, n, h, c, s, cin, corr;
        z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
        r = a; we = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                s = a + b + cin; r = s & 255; we = 1;
                h = ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0;
                c = s > 255 ? 1 : 0; n = 0; z = (r == 0);
            end
            2, 3, 7: begin
                cin = (op == 3) ? c : 0;
                s = a - b - cin;
                h = ((a & 15) - (b & 15) - cin) < 0 ? 1 : 0;
                c = s < 0 ? 1 : 0; n = 1; z = ((s & 255) == 0);
                if (op != 7) begin r = s & 255; we = 1; end
            end
            4, 5, 6: begin
                r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
                we = 1; z = (r == 0); n = 0; h = (op == 4); c = 0;
            end
            8: begin r = (a + 1) & 255; we = 1; z = (r == 0); n = 0; h = ((a & 15) == 15); end
            9: begin r = (a + 255) & 255; we = 1; z = (r == 0); n = 1; h = ((a & 15) == 0); end
            10: begin r = (~a) & 255; we = 1; n = 1; h = 1; end
            11: begin n = 0; h = 0; c = 1 - c; end
            12: begin n = 0; h = 0; c = 1; end
            13: begin
                corr = 0;
                if (n == 0) begin
                    if (h == 1 || (a & 15) > 9) corr += 6;
                    if (c == 1 || a > 153) begin corr += 96; c = 1; end
                    r = (a + corr) & 255;
                end else begin
                    if (h == 1) corr += 6;
                    if (c == 1) corr += 96;
                    r = (a - corr) & 255;
                end
                we = 1; z = (r == 0); h = 0;
            end
            default: ;
        endcase
        fo = (z << 7) | (n << 6) | (h << 5) | (c << 4);
    endtask

    // Apply one vector at the falling edge and compare a quarter period later
    task automatic run_vec(input int op, input int a, input int b, input int f, input string tag);
        int er, ewe, ef;
        @(negedge clk);
        op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[7:0];
        #(CLK_PERIOD/4);
        model(op, a, b, f, er, ewe, ef);
        total++;
        if (res_out !== er[7:0] || res_we !== ewe[0] || flags_out !== ef[7:0]) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h f=%h: res=%h/%h we=%0d/%0d flags=%h/%h",
                     tag, op, a[7:0], b[7:0], f[7:0], res_out, er[7:0], res_we, ewe,
                     flags_out, ef[7:0]);
        end
    endtask

    initial begin
        op_sel = 0; acc_in = 0; opnd_in = 0; flags_in = 0;
        // R1 initial all-zero vector: add of zeros gives Z only
        run_vec(0, 8'h00, 8'h00, 8'h00, "R1");
        // R2 nibble carry, byte carry with zero, carry-in
        run_vec(0, 8'h0F, 8'h01, 8'h00, "R2");
        run_vec(0, 8'hFF, 8'h01, 8'h00, "R2");
        run_vec(1, 8'hFE, 8'h01, 8'h10, "R2");
        // R3 nibble borrow, full borrow, borrow-in giving zero
        run_vec(2, 8'h10, 8'h01, 8'h00, "R3");
        run_vec(2, 8'h00, 8'h01, 8'h00, "R3");
        run_vec(3, 8'h06, 8'h05, 8'h10, "R3");
        // R4 compare equal and less
        run_vec(7, 8'h42, 8'h42, 8'h00, "R4");
        run_vec(7, 8'h10, 8'h20, 8'hF0, "R4");
        // R5 logic ops
        run_vec(4, 8'hF0, 8'h0F, 8'h10, "R5");
        run_vec(5, 8'h00, 8'h00, 8'hF0, "R5");
        run_vec(6, 8'hA5, 8'h5A, 8'h30, "R5");
        // R6 increment wrap keeps C, decrement to zero and nibble borrow
        run_vec(8, 8'hFF, 8'h00, 8'h10, "R6");
        run_vec(9, 8'h01, 8'h00, 8'h00, "R6");
        run_vec(9, 8'h00, 8'h00, 8'h10, "R6");
        // R7 complement
        run_vec(10, 8'h3C, 8'h00, 8'h90, "R7");
        // R8 carry flag operations
        run_vec(11, 8'h12, 8'h00, 8'hF0, "R8");
        run_vec(12, 8'h12, 8'h00, 8'h00, "R8");
        // R9 decimal adjust after add
        run_vec(13, 8'h0A, 8'h00, 8'h00, "R9");
        run_vec(13, 8'h9A, 8'h00, 8'h00, "R9");
        run_vec(13, 8'h12, 8'h00, 8'h30, "R9");
        // R10 decimal adjust after subtract
        run_vec(13, 8'h0F, 8'h00, 8'h60, "R10");
        run_vec(13, 8'hF0, 8'h00, 8'h50, "R10");
        // R11 undefined codes
        run_vec(14, 8'h77, 8'h11, 8'hA0, "R11");
        run_vec(15, 8'h00, 8'hFF, 8'h50, "R11");
        // R12 garbage in the low flag bits
        run_vec(0, 8'h01, 8'h02, 8'h0F, "R12");
        run_vec(11, 8'h01, 8'h02, 8'h0A, "R12");
        // Random sweep over all codes, operands and flag bytes
        for (int i = 0; i < 4000; i++) begin
            int op, a, b, f;
            op = $urandom_range(0, 15);
            a  = $urandom_range(0, 255);
            b  = $urandom_range(0, 255);
            f  = $urandom_range(0, 255);
            run_vec(op, a, b, f, (op == 13) ? (((f >> 6) & 1) != 0 ? "R10" : "R9") : req_tag(op));
        end
        done = 1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule